// File: doc/BRIEF.md
# Configurable GPIO Pin Controller

This block runs one general-purpose pin from a small set of registers. One configuration word sets the pin's direction, its polarity, its output type (push-pull or open-drain), its enable, the pull-resistor request and the interrupt mode. The same word selects what the pin drives in output mode: either a software-written level or one of eight internal status signals. Those signals are the done flags of two converter voltage changes, two external power enables, a system-supply-good flag, a power-good flag, a 2 MHz clock and an auxiliary reset. Polarity inversion applies on the way out. A power-domain bit in the word is stored and read back but drives nothing.

In input mode the pin passes through a two-flop synchroniser. Its polarity-adjusted level can be read back. Edges on the synchronised pin set a sticky interrupt status bit. In single-edge mode the polarity bit picks the edge: rising when the pin is active high, falling when it is active low. A separate mode bit makes both edges count. Software clears the status bit by writing 1 to it. An enable bit gates the interrupt output.

Register map: address 0 holds the configuration word. Address 1 holds status bit [0] (write 1 to clear), interrupt enable [1] (read/write) and the synchronised, polarity-adjusted pin level [2] (read-only). Reads are combinational.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset the configuration word (address 0) reads 0x0013, and address 1 reads 0 in bits [1:0]. Configuration fields: [0] direction (1 input, 0 output), [2:1] pull, [3] both-edge mode, [4] polarity (1 active high), [5] open-drain, [6] enable, [7] power domain, [11:8] source select, [12] output level.
- R2: When enable [6] is 0, pin_oe and pin_out are 0 whatever the other fields hold.
- R3: With enable set, direction output and open-drain clear, pin_oe is 1 and pin_out equals the selected value, inverted when polarity [4] is 0.
- R4: With open-drain [5] set in output mode, pin_out is always 0. pin_oe is 1 only when the polarity-adjusted value is 0, so a high releases the pin.
- R5: Source codes 8 to 15 in [11:8] select func_in[code-8]. Codes 0 to 7 select the output-level bit [12].
- R6: Pull field [2:1] value 01 asserts pull_dn only, 10 asserts pull_up only, and 00 or the reserved value 11 asserts neither.
- R7: Address 1 bit [2] shows the pin after two synchroniser flops, inverted when polarity is 0.
- R8: With both-edge [3] clear, a rising edge of the synchronised pin sets status when polarity is 1, and a falling edge sets it when polarity is 0. The other edge has no effect.
- R9: With both-edge [3] set, either edge sets status.
- R10: Status stays set until a write to address 1 with bit [0] = 1. irq is status AND interrupt enable [1].
- R11: Power-domain bit [7] reads back as written and changes no output.
- R12: Edges never set status unless enable is 1 and direction is input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address (0 config, 1 interrupt/status) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| func_in | input | 8 | Internal status signals for source codes 8..15 |
| pin_in | input | 1 | Pad input level, asynchronous |
| pin_out | output | 1 | Pad output level |
| pin_oe | output | 1 | Pad output enable |
| pull_up | output | 1 | Pull-up request |
| pull_dn | output | 1 | Pull-down request |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the write strobe and address are clean at each rising clock edge. They also assume func_in changes only between writes, so the cycle after a configuration write shows only the effect of that write. The bench drives every register access and every change of func_in and pin_in on the falling edge. It waits at least four cycles after each pin change before it samples or clears status, so stale synchroniser transitions never reach a later check.

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int NFUNC = 8,
  parameter int SELW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic [NFUNC-1:0] func_in,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             pull_up,
  output logic             pull_dn,
  output logic             irq
);
  localparam int CW    = 13;
  localparam int IW    = $clog2(NFUNC);
  localparam int FBASE = (1 << SELW) - NFUNC;
  localparam logic [CW-1:0] CFG_RST = 13'h0013;

  logic [CW-1:0]   cfg;
  logic            irq_st, irq_en;
  logic [2:0]      sync;
  logic            dir_in, both, pol, odrn, ena, lvl;
  logic [1:0]      pull;
  logic [SELW-1:0] sel, fidx;
  logic            src, drv, lvl_in, rise, fall, hit;
  logic            unused_bits;

  assign dir_in = cfg[0];
  assign pull   = cfg[2:1];
  assign both   = cfg[3];
  assign pol    = cfg[4];
  assign odrn   = cfg[5];
  assign ena    = cfg[6];
  assign sel    = cfg[11:8];
  assign lvl    = cfg[12];

  assign fidx = sel - SELW'(FBASE);
  assign src  = (int'(sel) >= FBASE) ? func_in[fidx[IW-1:0]] : lvl;
  assign drv  = src ^ ~pol;

  always_comb begin
    pin_out = 1'b0;
    pin_oe  = 1'b0;
    if (ena && !dir_in) begin
      if (odrn) pin_oe = ~drv;
      else begin
        pin_oe  = 1'b1;
        pin_out = drv;
      end
    end
  end

  assign pull_up = (pull == 2'b10);
  assign pull_dn = (pull == 2'b01);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], pin_in};

  assign lvl_in = sync[1] ^ ~pol;
  assign rise   = sync[1] & ~sync[2];
  assign fall   = ~sync[1] & sync[2];
  assign hit    = ena && dir_in && (both ? (rise | fall) : (pol ? rise : fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= CFG_RST;
      irq_st <= 1'b0;
      irq_en <= 1'b0;
    end else begin
      if (reg_wr && !reg_addr) cfg <= reg_wdata[CW-1:0];
      if (reg_wr && reg_addr) irq_en <= reg_wdata[1];
      if (hit) irq_st <= 1'b1;
      else if (reg_wr && reg_addr && reg_wdata[0]) irq_st <= 1'b0;
    end
  end

  assign irq       = irq_st & irq_en;
  assign reg_rdata = reg_addr ? {13'd0, lvl_in, irq_en, irq_st} : {{(16-CW){1'b0}}, cfg};

  assign unused_bits = ^{reg_wdata[15:CW], fidx};
endmodule

module gpio_pin_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_addr,
  input logic [15:0] reg_wdata,
  input logic        pin_out,
  input logic        pin_oe,
  input logic        pull_up,
  input logic        pull_dn,
  input logic        irq,
  input logic        irq_st
);
  AST_DISABLED_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && !reg_wdata[6]) |=> (!pin_oe && !pin_out)); // R2
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[5]) |=> !pin_out); // R4
  AST_PULL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[2:1] == 2'b11) |=> (!pull_up && !pull_dn)); // R6
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_st && !(reg_wr && reg_addr && reg_wdata[0])) |=> irq_st); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && !reg_wdata[1]) |=> !irq); // R10
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .pull_up(pull_up), .pull_dn(pull_dn), .irq(irq), .irq_st(irq_st)
);

// File: tb/test_gpio_pin_ctrl.sv
module test_gpio_pin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  func_in = '0;
  logic        pin_in = 1'b0;
  logic        pin_out, pin_oe, pull_up, pull_dn, irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  gpio_pin_ctrl i_gpio_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .func_in(func_in),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pull_up(pull_up), .pull_dn(pull_dn), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle(input logic v);
    @(negedge clk); pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(1'b0, d); chk("R1 cfg", d, 16'h0013);
    rd(1'b1, d); chk("R1 status", {14'd0, d[1:0]}, 16'h0);
    chk("R2 reset oe", {15'd0, pin_oe}, 16'h0);
    chk("R6 reset pulls", {14'd0, pull_up, pull_dn}, 16'h1);
  endtask

  task automatic t_cmos();
    wr(1'b0, 16'h1050);
    chk("R3 oe", {15'd0, pin_oe}, 16'h1);
    chk("R3 out high", {15'd0, pin_out}, 16'h1);
    wr(1'b0, 16'h1040);
    chk("R3 inverted", {15'd0, pin_out}, 16'h0);
    wr(1'b0, 16'h0040);
    chk("R3 inverted low", {15'd0, pin_out}, 16'h1);
  endtask

  task automatic t_disable();
    wr(1'b0, 16'h1010);
    chk("R2 disabled", {14'd0, pin_oe, pin_out}, 16'h0);
    wr(1'b0, 16'h1030);
    chk("R2 disabled od", {14'd0, pin_oe, pin_out}, 16'h0);
  endtask

  task automatic t_od();
    wr(1'b0, 16'h1070);
    chk("R4 release", {14'd0, pin_oe, pin_out}, 16'h0);
    wr(1'b0, 16'h0070);
    chk("R4 pull low", {14'd0, pin_oe, pin_out}, 16'h2);
  endtask

  task automatic t_func();
    for (int c = 8; c < 16; c++) begin
      wr(1'b0, 16'h0050 | 16'(c << 8));
      @(negedge clk); func_in = 8'(1 << (c - 8));
      #1 chk($sformatf("R5 code %0d hi", c), {15'd0, pin_out}, 16'h1);
      func_in = ~func_in;
      #1 chk($sformatf("R5 code %0d lo", c), {15'd0, pin_out}, 16'h0);
      func_in = '0;
    end
    wr(1'b0, 16'h1350);
    func_in = 8'hff;
    #1 chk("R5 code 3 uses level", {15'd0, pin_out}, 16'h1);
    wr(1'b0, 16'h0350);
    chk("R5 code 3 level low", {15'd0, pin_out}, 16'h0);
    func_in = '0;
  endtask

  task automatic t_pull();
    wr(1'b0, 16'h0015);
    chk("R6 up", {14'd0, pull_up, pull_dn}, 16'h2);
    wr(1'b0, 16'h0017);
    chk("R6 reserved", {14'd0, pull_up, pull_dn}, 16'h0);
    wr(1'b0, 16'h0011);
    chk("R6 none", {14'd0, pull_up, pull_dn}, 16'h0);
  endtask

  task automatic t_pwr();
    logic [15:0] d;
    logic [3:0] a;
    wr(1'b0, 16'h1050);
    a = {pin_oe, pin_out, pull_up, pull_dn};
    wr(1'b0, 16'h10d0);
    rd(1'b0, d); chk("R11 readback", d, 16'h10d0);
    chk("R11 no effect", {12'd0, pin_oe, pin_out, pull_up, pull_dn}, {12'd0, a});
  endtask

  task automatic t_level();
    logic [15:0] d;
    wr(1'b0, 16'h0051);
    settle(1'b1);
    rd(1'b1, d); chk("R7 level hi", {15'd0, d[2]}, 16'h1);
    wr(1'b0, 16'h0041);
    rd(1'b1, d); chk("R7 level inverted", {15'd0, d[2]}, 16'h0);
    @(negedge clk); pin_in = 1'b0;
    @(negedge clk);
    rd(1'b1, d); chk("R7 one flop not yet", {15'd0, d[2]}, 16'h0);
    @(negedge clk);
    rd(1'b1, d); chk("R7 after two flops", {15'd0, d[2]}, 16'h1);
    settle(1'b0);
  endtask

  task automatic edge_case(input string req, input logic [15:0] c, input logic from,
                           input logic [15:0] exp_st);
    logic [15:0] d;
    wr(1'b0, c);
    settle(from);
    wr(1'b1, 16'h0003);
    settle(~from);
    rd(1'b1, d); chk(req, {15'd0, d[0]}, exp_st);
    chk({req, " irq"}, {15'd0, irq}, exp_st);
  endtask

  task automatic t_edges();
    edge_case("R8 rise pol1", 16'h0051, 1'b0, 16'h1);
    edge_case("R8 fall pol1 ignored", 16'h0051, 1'b1, 16'h0);
    edge_case("R8 fall pol0", 16'h0041, 1'b1, 16'h1);
    edge_case("R8 rise pol0 ignored", 16'h0041, 1'b0, 16'h0);
    edge_case("R9 both rise", 16'h0059, 1'b0, 16'h1);
    edge_case("R9 both fall", 16'h0059, 1'b1, 16'h1);
    edge_case("R12 output mode", 16'h0050, 1'b0, 16'h0);
    edge_case("R12 disabled", 16'h0011, 1'b1, 16'h0);
  endtask

  task automatic t_sticky();
    logic [15:0] d;
    wr(1'b0, 16'h0059);
    settle(1'b0);
    wr(1'b1, 16'h0001);
    settle(1'b1);
    rd(1'b1, d); chk("R10 set while masked", {15'd0, d[0]}, 16'h1);
    chk("R10 masked irq", {15'd0, irq}, 16'h0);
    wr(1'b1, 16'h0002);
    repeat (10) @(negedge clk);
    rd(1'b1, d); chk("R10 sticky", {15'd0, d[0]}, 16'h1);
    chk("R10 irq enabled", {15'd0, irq}, 16'h1);
    wr(1'b1, 16'h0003);
    rd(1'b1, d); chk("R10 cleared", {15'd0, d[0]}, 16'h0);
    chk("R10 irq low", {15'd0, irq}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmos();
    t_disable();
    t_od();
    t_func();
    t_pull();
    t_pwr();
    t_level();
    t_edges();
    t_sticky();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule